// File: doc/BRIEF.md
# Idle sequencer with wake timer

This block puts a small controller into a low-power idle state and brings it back out. Software requests idle by writing a 1 to a write-only bit in the control register. While idle, the block stalls instruction fetch and drops the enables of the comparator and the brown-out detector. The oscillator, the PLL and a free-running wake timer keep running.

Idle ends on the first clock edge at which either the wake timer overflows or an enabled wakeup input is high. Normal execution resumes in the following cycle. A PWM timer that runs from the system clock is frozen while idle. One that runs from the PLL output keeps running. A status register records which source ended the last idle period. Software clears it with a write to the power-mode-clear address.

Top module: `idle_sequencer`

## Requirements
- R1: A write of 1 to bit 0 at address 0 while running makes `cpuStall` high from the cycle after the write edge. A write of 0 there has no effect, and address 0 always reads as 0.
- R2: The idle request bit clears itself. `cpuStall` falls in the cycle after the clock edge at which a wake condition is seen while idle, with no software action.
- R3: The wake timer is a 13-bit counter. It is 0 during reset and increments on every clock edge after reset. It overflows while it holds 8191, so a timer wake happens on an edge whose count since reset is a multiple of 8192.
- R4: Each wakeup input line ends idle only if its bit in the wake mask register is 1. The mask is at address 4, bit i for line i, and resets to 0. Unmasked lines are ignored.
- R5: `cmpEn` equals peripheral-config bit 0 and `borEn` equals bit 1, each forced to 0 while idle. The config register is at address 3 and resets to 2'b11.
- R6: `pwmRun` is 1 while running. While idle it equals `pwmClkFromPll`.
- R7: The status register at address 2 is written on each exit. Bit 0 is set when the exit came from timer overflow and bit 1 when it came from a wakeup input; both are set if both occurred. Any write to address 1 clears it to 0.
- R8: Register writes arriving while idle are ignored.
- R9: If an enabled wakeup input is already high in the cycle of the idle request, the block is idle for exactly one cycle.
- R10: After reset the block is running: `cpuStall` is 0, the status register is 0 and the wake mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address, used for both write and read |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data (combinational from regAddr) |
| wakeIn | input | 4 | Wakeup input lines |
| pwmClkFromPll | input | 1 | 1 when the PWM timer is clocked from the PLL |
| cpuStall | output | 1 | Holds instruction execution while idle |
| cmpEn | output | 1 | Comparator enable |
| borEn | output | 1 | Brown-out detector enable |
| pwmRun | output | 1 | PWM timer run enable |

## Verification
The bench sweeps every pairing of a nonzero wake mask with a wakeup pattern. A mask decode that is inverted or offset would exit on the wrong patterns, or would never exit at all. It measures timer wakes against its own count of edges since reset, so an off-by-one overflow compare shows up as an exit one cycle early or late. It also raises a wake input exactly in the overflow cycle to expect both status bits, and raises one in the same cycle as the request to expect a single-cycle stall. Writes attempted during idle must leave the peripheral config unchanged; a design that honoured them would read back a different value after the exit.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;
  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_PMC    = 1;
  localparam int unsigned REG_STATUS = 2;
  localparam int unsigned REG_PERIPH = 3;
  localparam int unsigned REG_WMASK  = 4;
  localparam int unsigned NPERIPH    = 2;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_IDLE = 1'b1
  } seqState_t;

  typedef struct packed {
    logic enterIdle;
    logic exitIdle;
    logic clrStatus;
    logic wrPeriph;
    logic wrMask;
  } seqStrobe_t;
endpackage

// File: rtl/idle_seq_ctrl.sv
module idle_seq_ctrl
  import idle_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrIdleBit,
  input  logic              wakeHit,
  output seqStrobe_t        strobe,
  output logic              isIdle
);
  seqState_t stateQ, stateNext;
  logic running;

  assign running = (stateQ == ST_RUN);
  assign isIdle  = (stateQ == ST_IDLE);

  // Register writes are decoded only while the CPU runs.
  always_comb begin
    strobe = '0;
    strobe.enterIdle = running && regWrEn && (regAddr == ADDR_W'(REG_CTRL)) && wrIdleBit;
    strobe.exitIdle  = isIdle && wakeHit;
    strobe.clrStatus = running && regWrEn && (regAddr == ADDR_W'(REG_PMC));
    strobe.wrPeriph  = running && regWrEn && (regAddr == ADDR_W'(REG_PERIPH));
    strobe.wrMask    = running && regWrEn && (regAddr == ADDR_W'(REG_WMASK));
  end

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_RUN:  if (strobe.enterIdle) stateNext = ST_IDLE;
      ST_IDLE: if (strobe.exitIdle)  stateNext = ST_RUN;
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateNext;
  end

  // R1: an idle request while running takes effect at the next edge
  a_r1_enter_idle: assert property (@(posedge clk) disable iff (!rstN)
    (running && regWrEn && regAddr == ADDR_W'(REG_CTRL) && wrIdleBit) |=> isIdle);

  // R2: a wake seen while idle returns to running at the next edge
  a_r2_self_clear: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && wakeHit) |=> !isIdle);

  // R8: no register strobe fires during idle
  a_r8_no_write_idle: assert property (@(posedge clk) disable iff (!rstN)
    isIdle |-> !(strobe.clrStatus || strobe.wrPeriph || strobe.wrMask));
endmodule

// File: rtl/idle_seq_datapath.sv
module idle_seq_datapath
  import idle_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NWAKE   = 4,
  parameter int unsigned TIMER_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              isIdle,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NWAKE-1:0]  wakeIn,
  input  logic              pwmClkFromPll,
  output logic              wakeHit,
  output logic              cmpEn,
  output logic              borEn,
  output logic              pwmRun
);
  localparam logic [TIMER_W-1:0] TMR_MAX = {TIMER_W{1'b1}};

  logic [TIMER_W-1:0] tmrQ;
  logic               tmrOvf;
  logic               inHit;
  logic [NWAKE-1:0]   wakeMaskQ;
  logic [NPERIPH-1:0] periphQ;
  logic [NPERIPH-1:0] periphOn;
  logic [1:0]         statusQ;
  logic               unusedWrBits;

  assign unusedWrBits = ^regWrData[DATA_W-1:NWAKE];

  // Free-running wake timer; keeps counting in both states.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tmrQ <= '0;
    else       tmrQ <= tmrQ + 1'b1;
  end
  assign tmrOvf  = (tmrQ == TMR_MAX);
  assign inHit   = |(wakeIn & wakeMaskQ);
  assign wakeHit = tmrOvf || inHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeMaskQ <= '0;
      periphQ   <= '1;
    end else begin
      if (strobe.wrMask)   wakeMaskQ <= regWrData[NWAKE-1:0];
      if (strobe.wrPeriph) periphQ   <= regWrData[NPERIPH-1:0];
    end
  end

  // Exit cause: bit 0 timer, bit 1 wake input.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 statusQ <= '0;
    else if (strobe.exitIdle)  statusQ <= {inHit, tmrOvf};
    else if (strobe.clrStatus) statusQ <= '0;
  end

  for (genvar p = 0; p < NPERIPH; p++) begin : g_periph
    assign periphOn[p] = periphQ[p] && !isIdle;
  end
  assign cmpEn  = periphOn[0];
  assign borEn  = periphOn[1];
  assign pwmRun = !isIdle || pwmClkFromPll;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(REG_STATUS))      regRdData[1:0]         = statusQ;
    else if (regAddr == ADDR_W'(REG_PERIPH)) regRdData[NPERIPH-1:0] = periphQ;
    else if (regAddr == ADDR_W'(REG_WMASK))  regRdData[NWAKE-1:0]   = wakeMaskQ;
  end

  // R3: the timer wraps to zero after its last value
  a_r3_timer_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (tmrQ == TMR_MAX) |=> (tmrQ == '0));

  // R5: peripheral enables are low throughout idle
  a_r5_periph_off: assert property (@(posedge clk) disable iff (!rstN)
    isIdle |-> (!cmpEn && !borEn));

  // R6: a system-clocked PWM timer is frozen in idle
  a_r6_pwm_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && !pwmClkFromPll) |-> !pwmRun);

  // R7: a clear write empties the status register
  a_r7_status_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrStatus |=> (statusQ == 2'b00));

  // R8: configuration holds while idle
  a_r8_cfg_stable: assert property (@(posedge clk) disable iff (!rstN)
    isIdle |=> ($stable(periphQ) && $stable(wakeMaskQ)));
endmodule

// File: rtl/idle_sequencer.sv
module idle_sequencer
  import idle_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NWAKE   = 4,
  parameter int unsigned TIMER_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NWAKE-1:0]  wakeIn,
  input  logic              pwmClkFromPll,
  output logic              cpuStall,
  output logic              cmpEn,
  output logic              borEn,
  output logic              pwmRun
);
  seqStrobe_t strobe;
  logic       isIdle;
  logic       wakeHit;

  idle_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .wrIdleBit (regWrData[0]),
    .wakeHit   (wakeHit),
    .strobe    (strobe),
    .isIdle    (isIdle)
  );

  idle_seq_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NWAKE  (NWAKE),
    .TIMER_W(TIMER_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .isIdle       (isIdle),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .wakeIn       (wakeIn),
    .pwmClkFromPll(pwmClkFromPll),
    .wakeHit      (wakeHit),
    .cmpEn        (cmpEn),
    .borEn        (borEn),
    .pwmRun       (pwmRun)
  );

  assign cpuStall = isIdle;

  // R10: the stall output is low after reset
  a_r10_reset_run: assert property (@(posedge clk) $rose(rstN) |-> !cpuStall);
endmodule

// File: tb/idle_sequencer_bench.sv
module idle_sequencer_bench;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int NW = 4;
  localparam int PERIOD = 8192;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic [NW-1:0] wakeIn = '0;
  logic          pwmClkFromPll = 1'b0;
  logic          cpuStall, cmpEn, borEn, pwmRun;

  int edges = 0;
  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) if (rstN) edges <= edges + 1;

  idle_sequencer u_idle_sequencer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .wakeIn(wakeIn),
    .pwmClkFromPll(pwmClkFromPll), .cpuStall(cpuStall), .cmpEn(cmpEn),
    .borEn(borEn), .pwmRun(pwmRun)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = AW'(addr); regWrData = DW'(data);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input int addr, input int exp, input string req);
    regAddr = AW'(addr);
    #1;
    chk(req, int'(regRdData), exp);
  endtask

  task automatic guardTimer();
    while ((edges % PERIOD) > PERIOD - 100) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R10 stall", cpuStall, 0);
    chk("R5 cmpEn", cmpEn, 1);
    chk("R5 borEn", borEn, 1);
    chk("R6 pwmRun", pwmRun, 1);
    rdChk(2, 0, "R10 status");
    rdChk(4, 0, "R10 mask");
    rdChk(3, 3, "R5 cfg");
    // Writing 0 to the idle bit does nothing; bit reads as 0
    wr(0, 0);
    chk("R1 write0", cpuStall, 0);
    rdChk(0, 0, "R1 readback");

    // Mask x pattern sweep
    for (int m = 1; m < 16; m++) begin
      for (int p = 0; p < 16; p++) begin
        bit hit;
        bit sel;
        hit = ((p & m) != 0);
        sel = p[0] ^ m[1];
        guardTimer();
        wakeIn = '0;
        pwmClkFromPll = sel;
        wr(4, m);
        wr(0, 1);
        chk("R1 enter", cpuStall, 1);
        chk("R5 idle off", {30'd0, cmpEn, borEn}, 0);
        chk("R6 pwm", pwmRun, int'(sel));
        rdChk(0, 0, "R1 readback idle");
        wakeIn = NW'(p);
        @(negedge clk);
        chk("R4 mask decode", cpuStall, hit ? 0 : 1);
        if (!hit) begin
          wr(3, 0);
          wr(1, 0);
          chk("R4 still idle", cpuStall, 1);
          wakeIn = NW'(m);
          @(negedge clk);
        end
        chk("R2 resumed", cpuStall, 0);
        chk("R5 restored", {30'd0, cmpEn, borEn}, 3);
        rdChk(3, 3, "R8 cfg kept");
        rdChk(2, 2, "R7 input cause");
        wakeIn = '0;
        wr(1, 0);
        rdChk(2, 0, "R7 cleared");
      end
    end

    // Timer wake with no inputs enabled, PWM on PLL clock
    wakeIn = '0;
    pwmClkFromPll = 1'b1;
    wr(4, 0);
    wr(0, 1);
    chk("R6 pll pwm", pwmRun, 1);
    begin
      int w = 0;
      while (cpuStall && w < PERIOD + 50) begin
        @(negedge clk);
        w++;
      end
    end
    chk("R3 overflow phase", edges % PERIOD, 0);
    chk("R2 timer resume", cpuStall, 0);
    rdChk(2, 1, "R7 timer cause");
    wr(1, 0);

    // Input and overflow in the same cycle
    guardTimer();
    wr(4, 1);
    wr(0, 1);
    while ((edges % PERIOD) != PERIOD - 1) @(negedge clk);
    chk("R3 idle before ovf", cpuStall, 1);
    wakeIn = 4'b0001;
    @(negedge clk);
    chk("R3 both resume", cpuStall, 0);
    rdChk(2, 3, "R7 both causes");
    wakeIn = '0;
    wr(1, 0);

    // Wake already present with the request
    guardTimer();
    wr(4, 2);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = AW'(0); regWrData = DW'(1); wakeIn = 4'b0010;
    @(negedge clk);
    regWrEn = 1'b0;
    chk("R9 one idle cycle", cpuStall, 1);
    @(negedge clk);
    chk("R9 exit", cpuStall, 0);
    wakeIn = '0;
    rdChk(2, 2, "R9 status");
    wr(1, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule